// File: doc/BRIEF.md
# SATA Host Port Register Bank

This block holds the control and status registers of one port of a SATA host adapter. Software reaches it through a 32-bit register interface that carries a byte offset. The byte offset is turned into a word index. Each word applies its own write rule: plain store, masked store, write-one-to-clear, write-one-to-set, or read-only. Reads return one cycle after the request.

Hardware around the port supplies three kinds of input. The first is event bits that raise pending interrupt and error status. The second is completion bits that retire issued and active command slots. The third is the live values behind the read-only words and the read-only fields of the command word. The block drives three outputs. A level interrupt comes from pending status gated by the enables. A one-cycle port-reset request fires when software releases the link detection control from its "reset" value. A one-cycle command-check strobe tells the command engine to look again.

Top module: `sata_port_regs`

## Requirements
- R1: After reset every stored word is zero, and port_irq, port_reset_req, cmd_check, rsp_err and rsp_rdata are low.
- R2: The word index is req_offset divided by 4, and offset bits 1:0 are ignored. An index of 32 or more (offset 0x80 and up) gives rsp_err high for one cycle and changes no state. Indices 7 and 15 to 31 are reserved: writes have no effect, reads return 0, and no error is raised.
- R3: Indices 0 to 3 (list base low and high, FIS base low and high) store all 32 written bits and read them back.
- R4: Index 4 (pending interrupts) sets bits from irq_set and clears bits written as 1. Bits written as 0 are unchanged. An irq_set bit in the same cycle as a clear of that bit leaves it set.
- R5: Index 5 (interrupt enables) keeps only the written bits inside 0xFDC000FF. All other bits read 0.
- R6: port_irq is high exactly when the bitwise AND of index 4 and index 5 is non-zero. It follows their stored values with no extra delay.
- R7: Index 6 (command) stores only the written bits in 0xF000001F. Every other bit reads the matching bit of hw_cmd_status, which covers list-running at bit 15 and FIS-running at bit 14. Writes cannot change those bits.
- R8: Indices 8, 9 and 10 read hw_tfd, hw_sig and hw_ssts. Writes to them have no effect.
- R9: Index 11 (link control) stores the written value. When its stored bits 3:0 equal 1 and the written bits 3:0 equal 0, port_reset_req pulses high for exactly one cycle after the write.
- R10: Index 12 (link error) sets bits from err_set and clears bits written as 1.
- R11: Index 13 (active slots) and index 14 (issued slots) OR written 1 bits into their value. A cmd_done bit clears the same bit in both. A cmd_done bit and a written 1 in the same cycle leave that bit set.
- R12: A write to index 6 or index 14 gives cmd_check high for exactly one cycle after the write. Writes to other indices do not.
- R13: rsp_rdata takes the addressed value one cycle after a read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset inside the port space |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| rsp_err | output | 1 | Out-of-window request, one cycle after it |
| irq_set | input | 32 | Event bits raising pending interrupts |
| err_set | input | 32 | Event bits raising link errors |
| cmd_done | input | 32 | Slot completion bits |
| hw_cmd_status | input | 32 | Live read-only fields of the command word |
| hw_tfd | input | 32 | Task-file data value |
| hw_sig | input | 32 | Device signature value |
| hw_ssts | input | 32 | Link status value |
| port_irq | output | 1 | Port interrupt level |
| port_reset_req | output | 1 | One-cycle port reset request |
| cmd_check | output | 1 | One-cycle command re-evaluation strobe |

## Verification
Each write rule gets the same pattern: an all-ones write followed by a selective write. This separates a masked store from a plain store, and a set rule from a clear rule. An all-ones write into the enables and the command word shows the fixed mask and the merge with the live command fields. Status words see event pulses, zero writes, one writes, and an event and a clear in the same cycle, so the set-wins priority is pinned down. The link control word sees the release from 1 to 0 and releases from 0 and from 2, which tells the falling-edge trigger apart from a level test. Offsets below, inside the reserved range and above the window separate the error path from silently ignored words.

// File: rtl/sata_port_pkg.sv
package sata_port_pkg;

   localparam int REG_W   = 32;
   localparam int NUM_REG = 15;

   // word indices whose position software relies on
   localparam int IX_CLB_LO = 0;
   localparam int IX_CLB_HI = 1;
   localparam int IX_FB_LO  = 2;
   localparam int IX_FB_HI  = 3;
   localparam int IX_ISTAT  = 4;
   localparam int IX_IEN    = 5;
   localparam int IX_CMD    = 6;
   localparam int IX_TFD    = 8;
   localparam int IX_SIG    = 9;
   localparam int IX_SSTS   = 10;
   localparam int IX_SCTL   = 11;
   localparam int IX_SERR   = 12;
   localparam int IX_SACT   = 13;
   localparam int IX_CI     = 14;

   typedef enum logic [2:0] {
      WR_NONE,
      WR_PLAIN,
      WR_MASKED,
      WR_W1C,
      WR_W1S,
      WR_RO
   } wrule_e;

   function automatic wrule_e rule_of(input int ix);
      case (ix)
         IX_CLB_LO, IX_CLB_HI, IX_FB_LO, IX_FB_HI, IX_SCTL: rule_of = WR_PLAIN;
         IX_IEN, IX_CMD:                                   rule_of = WR_MASKED;
         IX_ISTAT, IX_SERR:                                rule_of = WR_W1C;
         IX_SACT, IX_CI:                                   rule_of = WR_W1S;
         IX_TFD, IX_SIG, IX_SSTS:                          rule_of = WR_RO;
         default:                                          rule_of = WR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sata_port_decode.sv
module sata_port_decode #(
   parameter int ADDR_W    = 8,
   parameter int WIN_WORDS = 32,
   parameter int NUM_REG   = 15,
   parameter int IDX_W     = ADDR_W - 2
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_offset,
   output logic [IDX_W-1:0]     word_idx,
   output logic                 in_win,
   output logic                 rd_fire,
   output logic [NUM_REG-1:0]   wr_sel
);

   localparam logic [IDX_W:0] WIN_L = (IDX_W+1)'(WIN_WORDS);

   logic       wr_ok;
   logic [1:0] unused_lsb;

   assign unused_lsb = req_offset[1:0];
   assign word_idx   = req_offset[ADDR_W-1:2];
   assign in_win     = ({1'b0, word_idx} < WIN_L);
   assign wr_ok      = req_valid & req_write & in_win;
   assign rd_fire    = req_valid & ~req_write;

   for (genvar g = 0; g < NUM_REG; g++) begin : g_sel
      assign wr_sel[g] = wr_ok && (word_idx == IDX_W'(g));
   end

endmodule

// File: rtl/sata_port_field.sv
module sata_port_field
   import sata_port_pkg::*;
#(
   parameter wrule_e         RULE = WR_PLAIN,
   parameter int             W    = 32,
   parameter logic [W-1:0]   MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  hw_set,
   input  logic [W-1:0]  hw_clr,
   output logic [W-1:0]  q
);

   logic [W-1:0] q_r;
   logic [W-1:0] nxt;
   logic [W-1:0] held;
   logic [W-1:0] wv;

   always_comb begin
      wv   = we ? wdata : '0;
      held = (q_r & ~hw_clr) | hw_set;
   end

   if (RULE == WR_W1C) begin : g_w1c
      // hardware set wins over a software clear of the same bit
      always_comb nxt = ((held & ~wv) | hw_set) & MASK;
   end else if (RULE == WR_W1S) begin : g_w1s
      // completion clear first, then software set
      always_comb nxt = (held | wv) & MASK;
   end else if (RULE == WR_PLAIN || RULE == WR_MASKED) begin : g_store
      always_comb nxt = (we ? wdata : held) & MASK;
   end else begin : g_bad
      $error("sata_port_field: rule has no storage");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt;
   end

   assign q = q_r;

endmodule

// File: rtl/sata_port_readmux.sv
module sata_port_readmux #(
   parameter int IDX_W   = 6,
   parameter int NUM_REG = 15,
   parameter int W       = 32
) (
   input  logic [IDX_W-1:0]             idx,
   input  logic                         in_win,
   input  logic [NUM_REG-1:0][W-1:0]    vals,
   output logic [W-1:0]                 data
);

   always_comb begin
      data = '0;
      for (int k = 0; k < NUM_REG; k++) begin
         if (in_win && (idx == IDX_W'(k))) data = vals[k];
      end
   end

endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
   import sata_port_pkg::*;
#(
   parameter int           ADDR_W    = 8,
   parameter int           WIN_WORDS = 32,
   parameter int           DET_W     = 4,
   parameter logic [31:0]  IEN_MASK  = 32'hFDC0_00FF,
   parameter logic [31:0]  CMD_WMASK = 32'hF000_001F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_offset,
   input  logic [31:0]         req_wdata,
   output logic [31:0]         rsp_rdata,
   output logic                rsp_err,
   input  logic [31:0]         irq_set,
   input  logic [31:0]         err_set,
   input  logic [31:0]         cmd_done,
   input  logic [31:0]         hw_cmd_status,
   input  logic [31:0]         hw_tfd,
   input  logic [31:0]         hw_sig,
   input  logic [31:0]         hw_ssts,
   output logic                port_irq,
   output logic                port_reset_req,
   output logic                cmd_check
);

   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_chk_addr
      $error("sata_port_regs: ADDR_W too small");
   end
   if (WIN_WORDS > (1 << IDX_W)) begin : g_chk_win
      $error("sata_port_regs: window larger than offset range");
   end
   if (NUM_REG > WIN_WORDS) begin : g_chk_num
      $error("sata_port_regs: defined words exceed window");
   end
   if (DET_W < 1 || DET_W > REG_W) begin : g_chk_det
      $error("sata_port_regs: DET_W out of range");
   end

   function automatic logic [REG_W-1:0] mask_of(input int ix);
      case (ix)
         IX_IEN:  mask_of = IEN_MASK;
         IX_CMD:  mask_of = CMD_WMASK;
         default: mask_of = '1;
      endcase
   endfunction

   logic [IDX_W-1:0]               word_idx;
   logic                           in_win;
   logic                           rd_fire;
   logic [NUM_REG-1:0]             wr_sel;
   logic [NUM_REG-1:0][REG_W-1:0]  q_v;
   logic [NUM_REG-1:0][REG_W-1:0]  vals;
   logic [REG_W-1:0]               rd_data;
   logic                           det_release;

   sata_port_decode #(
      .ADDR_W    (ADDR_W),
      .WIN_WORDS (WIN_WORDS),
      .NUM_REG   (NUM_REG),
      .IDX_W     (IDX_W)
   ) u_dec (
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_offset (req_offset),
      .word_idx   (word_idx),
      .in_win     (in_win),
      .rd_fire    (rd_fire),
      .wr_sel     (wr_sel)
   );

   for (genvar g = 0; g < NUM_REG; g++) begin : g_word
      localparam wrule_e RL = rule_of(g);
      logic [REG_W-1:0] ovl;

      if (g == IX_CMD) begin : g_ovl_cmd
         assign ovl = hw_cmd_status & ~CMD_WMASK;
      end else if (g == IX_TFD) begin : g_ovl_tfd
         assign ovl = hw_tfd;
      end else if (g == IX_SIG) begin : g_ovl_sig
         assign ovl = hw_sig;
      end else if (g == IX_SSTS) begin : g_ovl_ssts
         assign ovl = hw_ssts;
      end else begin : g_ovl_none
         assign ovl = '0;
      end

      if (RL == WR_NONE || RL == WR_RO) begin : g_fixed
         assign q_v[g] = '0;
      end else begin : g_reg
         logic [REG_W-1:0] s_in;
         logic [REG_W-1:0] c_in;

         if (g == IX_ISTAT) begin : g_s_irq
            assign s_in = irq_set;
         end else if (g == IX_SERR) begin : g_s_err
            assign s_in = err_set;
         end else begin : g_s_none
            assign s_in = '0;
         end

         if (g == IX_SACT || g == IX_CI) begin : g_c_done
            assign c_in = cmd_done;
         end else begin : g_c_none
            assign c_in = '0;
         end

         sata_port_field #(
            .RULE (RL),
            .W    (REG_W),
            .MASK (mask_of(g))
         ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_sel[g]),
            .wdata  (req_wdata),
            .hw_set (s_in),
            .hw_clr (c_in),
            .q      (q_v[g])
         );
      end

      assign vals[g] = q_v[g] | ovl;
   end

   sata_port_readmux #(
      .IDX_W   (IDX_W),
      .NUM_REG (NUM_REG),
      .W       (REG_W)
   ) u_rmux (
      .idx    (word_idx),
      .in_win (in_win),
      .vals   (vals),
      .data   (rd_data)
   );

   assign det_release = wr_sel[IX_SCTL]
                     && (q_v[IX_SCTL][DET_W-1:0] == DET_W'(1))
                     && (req_wdata[DET_W-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_rdata      <= '0;
         rsp_err        <= 1'b0;
         port_reset_req <= 1'b0;
         cmd_check      <= 1'b0;
      end else begin
         rsp_err        <= req_valid & ~in_win;
         port_reset_req <= det_release;
         cmd_check      <= wr_sel[IX_CMD] | wr_sel[IX_CI];
         if (rd_fire) rsp_rdata <= rd_data;
      end
   end

   assign port_irq = |(vals[IX_ISTAT] & vals[IX_IEN]);

endmodule

// File: rtl/sata_port_regs_chk.sv
module sata_port_regs_chk #(
   parameter int ADDR_W    = 8,
   parameter int WIN_WORDS = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic [ADDR_W-1:0]  req_offset,
   input logic [31:0]        req_wdata,
   input logic [31:0]        rsp_rdata,
   input logic               rsp_err,
   input logic               port_reset_req,
   input logic               cmd_check
);

   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W:0] widx;
   assign widx = {1'b0, req_offset[ADDR_W-1:2]};

   // R2: out-of-window request raises the error flag
   p_err_oob_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (widx >= (IDX_W+1)'(WIN_WORDS))) |=> rsp_err);

   // R2: in-window or idle cycle never raises the error flag
   p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && (widx >= (IDX_W+1)'(WIN_WORDS))) |=> !rsp_err);

   // R9: reset request only after a link-control write with zero detection field
   p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      port_reset_req |-> $past(req_valid && req_write
                               && (widx == (IDX_W+1)'(11))
                               && (req_wdata[3:0] == 4'd0)));

   // R9: the reset request lasts a single cycle
   p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      port_reset_req |=> !port_reset_req);

   // R12: command or issue write produces the strobe
   p_chk_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (widx == (IDX_W+1)'(6) || widx == (IDX_W+1)'(14)))
      |=> cmd_check);

   // R12: strobe only follows such a write
   p_chk_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && (widx == (IDX_W+1)'(6) || widx == (IDX_W+1)'(14)))
      |=> !cmd_check);

   // R13: read data holds when no read was requested
   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> $stable(rsp_rdata));

endmodule

bind sata_port_regs sata_port_regs_chk #(
   .ADDR_W    (ADDR_W),
   .WIN_WORDS (WIN_WORDS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .req_offset     (req_offset),
   .req_wdata      (req_wdata),
   .rsp_rdata      (rsp_rdata),
   .rsp_err        (rsp_err),
   .port_reset_req (port_reset_req),
   .cmd_check      (cmd_check)
);

// File: tb/sata_port_regs_bench.sv
module sata_port_regs_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic [31:0] irq_set = '0;
   logic [31:0] err_set = '0;
   logic [31:0] cmd_done = '0;
   logic [31:0] hw_cmd_status = '0;
   logic [31:0] hw_tfd = '0;
   logic [31:0] hw_sig = '0;
   logic [31:0] hw_ssts = '0;
   logic        port_irq;
   logic        port_reset_req;
   logic        cmd_check;

   int total = 0;
   int bad   = 0;
   logic done = 1'b0;

   logic        s_err, s_rst, s_chk;
   logic [31:0] rd_v;
   logic        rd_e;

   always #(CLK_P/2) clk = ~clk;

   sata_port_regs u_sata_port_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_offset     (req_offset),
      .req_wdata      (req_wdata),
      .rsp_rdata      (rsp_rdata),
      .rsp_err        (rsp_err),
      .irq_set        (irq_set),
      .err_set        (err_set),
      .cmd_done       (cmd_done),
      .hw_cmd_status  (hw_cmd_status),
      .hw_tfd         (hw_tfd),
      .hw_sig         (hw_sig),
      .hw_ssts        (hw_ssts),
      .port_irq       (port_irq),
      .port_reset_req (port_reset_req),
      .cmd_check      (cmd_check)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] off, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d;
      @(negedge clk);
      s_err = rsp_err; s_rst = port_reset_req; s_chk = cmd_check;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] off);
      req_valid = 1'b1; req_write = 1'b0; req_offset = off;
      @(negedge clk);
      rd_v = rsp_rdata; rd_e = rsp_err;
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq", {31'b0, port_irq}, 0);
      chk("R1 rst", {31'b0, port_reset_req}, 0);
      chk("R1 chk", {31'b0, cmd_check}, 0);
      chk("R1 rdata", rsp_rdata, 0);
      for (int i = 0; i < 15; i++) begin
         rd(8'(i * 4));
         chk("R1 word", rd_v, 0);
      end
   endtask

   task automatic t_plain();
      for (int i = 0; i < 4; i++) wr(8'(i * 4), 32'hA5A5_0000 + 32'(i * 32'h1111));
      for (int i = 0; i < 4; i++) begin
         rd(8'(i * 4));
         chk("R3 plain", rd_v, 32'hA5A5_0000 + 32'(i * 32'h1111));
         chk("R13 no err", {31'b0, rd_e}, 0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk("R13 hold", rsp_rdata, 32'hA5A5_3333);
   endtask

   task automatic t_window();
      wr(8'h80, 32'hFFFF_FFFF);
      chk("R2 err wr", {31'b0, s_err}, 1);
      wr(8'hFC, 32'h1234_5678);
      chk("R2 err hi", {31'b0, s_err}, 1);
      rd(8'h80);
      chk("R2 err rd", {31'b0, rd_e}, 1);
      rd(8'h00);
      chk("R2 unchanged", rd_v, 32'hA5A5_0000);
      wr(8'h1C, 32'hFFFF_FFFF);
      chk("R2 rsvd no err", {31'b0, s_err}, 0);
      rd(8'h1C);
      chk("R2 rsvd read", rd_v, 0);
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40);
      chk("R2 rsvd hi", rd_v, 0);
      wr(8'h07, 32'h0BAD_CAFE);
      rd(8'h04);
      chk("R2 lsb ignored", rd_v, 32'h0BAD_CAFE);
   endtask

   task automatic t_irq();
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14);
      chk("R5 mask", rd_v, 32'hFDC0_00FF);
      irq_set = 32'h0000_0101;
      @(negedge clk);
      irq_set = '0;
      rd(8'h10);
      chk("R4 set", rd_v, 32'h0000_0101);
      chk("R6 irq high", {31'b0, port_irq}, 1);
      wr(8'h10, 32'h0);
      rd(8'h10);
      chk("R4 zero write", rd_v, 32'h0000_0101);
      wr(8'h10, 32'h0000_0001);
      chk("R6 irq low", {31'b0, port_irq}, 0);
      rd(8'h10);
      chk("R4 clear", rd_v, 32'h0000_0100);
      irq_set = 32'h0000_0002;
      wr(8'h10, 32'h0000_0002);
      irq_set = '0;
      rd(8'h10);
      chk("R4 set wins", rd_v, 32'h0000_0102);
      chk("R6 irq enabled bit", {31'b0, port_irq}, 1);
      wr(8'h10, 32'hFFFF_FFFF);
      chk("R6 irq cleared", {31'b0, port_irq}, 0);
      wr(8'h14, 32'h0);
      irq_set = 32'h0000_0001;
      @(negedge clk);
      irq_set = '0;
      chk("R6 disabled", {31'b0, port_irq}, 0);
   endtask

   task automatic t_cmd();
      hw_cmd_status = 32'h0000_C000;
      wr(8'h18, 32'hFFFF_FFFF);
      chk("R12 cmd strobe", {31'b0, s_chk}, 1);
      @(negedge clk);
      chk("R12 one cycle", {31'b0, cmd_check}, 0);
      rd(8'h18);
      chk("R7 merge", rd_v, 32'hF000_C01F);
      hw_cmd_status = 32'h0;
      wr(8'h18, 32'h0000_C001);
      rd(8'h18);
      chk("R7 ro blocked", rd_v, 32'h0000_0001);
      wr(8'h00, 32'h1);
      chk("R12 no strobe", {31'b0, s_chk}, 0);
   endtask

   task automatic t_ro();
      hw_tfd = 32'h0000_0050; hw_sig = 32'h0000_0101; hw_ssts = 32'h0000_0123;
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h20); chk("R8 tfd", rd_v, 32'h0000_0050);
      rd(8'h24); chk("R8 sig", rd_v, 32'h0000_0101);
      rd(8'h28); chk("R8 ssts", rd_v, 32'h0000_0123);
      hw_tfd = '0; hw_sig = '0; hw_ssts = '0;
      rd(8'h20); chk("R8 live", rd_v, 0);
   endtask

   task automatic t_sctl();
      wr(8'h2C, 32'h0000_0001);
      chk("R9 set no pulse", {31'b0, s_rst}, 0);
      wr(8'h2C, 32'h0000_0300);
      chk("R9 release pulse", {31'b0, s_rst}, 1);
      @(negedge clk);
      chk("R9 one cycle", {31'b0, port_reset_req}, 0);
      rd(8'h2C);
      chk("R9 stored", rd_v, 32'h0000_0300);
      wr(8'h2C, 32'h0);
      chk("R9 from zero", {31'b0, s_rst}, 0);
      wr(8'h2C, 32'h2);
      wr(8'h2C, 32'h0);
      chk("R9 from two", {31'b0, s_rst}, 0);
   endtask

   task automatic t_serr();
      err_set = 32'h0401_0002;
      @(negedge clk);
      err_set = '0;
      wr(8'h30, 32'h0001_0000);
      rd(8'h30);
      chk("R10 w1c", rd_v, 32'h0400_0002);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30);
      chk("R10 all clear", rd_v, 0);
   endtask

   task automatic t_w1s();
      wr(8'h38, 32'h0000_0001);
      chk("R12 issue strobe", {31'b0, s_chk}, 1);
      wr(8'h38, 32'h0000_0004);
      rd(8'h38);
      chk("R11 ci or", rd_v, 32'h0000_0005);
      wr(8'h34, 32'h0000_0003);
      wr(8'h34, 32'h0);
      rd(8'h34);
      chk("R11 sact or", rd_v, 32'h0000_0003);
      cmd_done = 32'h0000_0001;
      @(negedge clk);
      cmd_done = '0;
      rd(8'h38);
      chk("R11 ci done", rd_v, 32'h0000_0004);
      rd(8'h34);
      chk("R11 sact done", rd_v, 32'h0000_0002);
      cmd_done = 32'h0000_0004;
      wr(8'h38, 32'h0000_0004);
      cmd_done = '0;
      rd(8'h38);
      chk("R11 set wins", rd_v, 32'h0000_0004);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_window();
      t_irq();
      t_cmd();
      t_ro();
      t_sctl();
      t_serr();
      t_w1s();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

endmodule